// File: doc/BRIEF.md
# Receive Special-Character Matcher with In-Band Flow Control

This block sits between the receive side of an asynchronous serial channel and the logic that consumes received characters, and between a transmit FIFO and the transmitter. Every received character is compared against two programmable character values. In plain detect mode a matching character is passed on with a flag telling which value it matched. When in-band flow control is also enabled, the first value acts as a resume character and the second as a pause character. These characters are removed from the receive stream, and they raise or drop a transmit-stop output that holds back FIFO data.

The transmit side can also send one of the two programmed characters on request. The request takes effect at the next character boundary, ahead of any FIFO byte still waiting, and the block reports the send with a one-cycle acknowledge. Both character streams use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. A source that raises valid must hold its data stable until the transfer happens. Configuration and request pins are plain levels or strobes.

Top module: `spchar_flow`

## Requirements
- R1: Both character registers reset to 0x00. A write strobe `chr_we[0]` loads `chr_wdata` into register A (the resume character), and `chr_we[1]` loads it into register B (the pause character), on the clock edge.
- R2: In detect mode (`cfg_async`=1, `cfg_detect`=1, `cfg_flow`=0) every received character is passed to the output unchanged. `out_hit_a` is 1 when it equals register A, and `out_hit_b` is 1 when it equals register B.
- R3: When `cfg_detect`=0 or `cfg_async`=0, both hit flags are 0. Characters are passed on, and no character changes `tx_stop`.
- R4: A character with `rx_err`=1 is passed on with `out_err`=1, with no hit flags and no flow-control action, unless `cfg_err_chk`=1. With `cfg_err_chk`=1 it is matched like any other character.
- R5: In flow mode (`cfg_async`, `cfg_detect` and `cfg_flow` all 1) a matching character is consumed and never appears at the output. Accepting a register-B match sets `tx_stop` from the next cycle on. Accepting a register-A match clears it. If a character matches both registers, it sets `tx_stop`.
- R6: While `tx_stop`=1, no new FIFO byte is offered: `tx_valid` stays 0 and `fifo_ready` stays 0 unless a special character is pending.
- R7: A one-cycle `sc_req` with `sc_sel` (0 = register A, 1 = register B) queues that register's value. It is offered on `tx_data` ahead of any FIFO byte not already offered, even while `tx_stop`=1. `sc_ack` pulses for exactly the cycle in which it is transferred. A request made while one is pending is ignored.
- R8: Once `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` stay unchanged in the next cycle.
- R9: `rx_ready` follows `out_ready` for characters that are passed on. A consumed flow character is accepted regardless of `out_ready`.
- R10: Reset clears `tx_stop`. Leaving flow mode clears `tx_stop` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_async | input | 1 | Asynchronous mode selected |
| cfg_detect | input | 1 | Special-character detection enable |
| cfg_flow | input | 1 | In-band transmit flow-control enable |
| cfg_err_chk | input | 1 | Process characters with receive errors too |
| chr_we | input | 2 | Write strobes for registers A and B |
| chr_wdata | input | 8 | Write data for the character registers |
| rx_valid | input | 1 | Received character valid |
| rx_ready | output | 1 | Block accepts received character |
| rx_data | input | 8 | Received character |
| rx_err | input | 1 | Received character has an error |
| out_valid | output | 1 | Passed-on character valid |
| out_ready | input | 1 | Consumer accepts character |
| out_data | output | 8 | Passed-on character |
| out_err | output | 1 | Passed-on character error flag |
| out_hit_a | output | 1 | Character matched register A |
| out_hit_b | output | 1 | Character matched register B |
| tx_stop | output | 1 | Transmission paused by flow control |
| sc_req | input | 1 | Special-character send request strobe |
| sc_sel | input | 1 | Register to send: 0 = A, 1 = B |
| sc_ack | output | 1 | Special character transferred this cycle |
| fifo_valid | input | 1 | Transmit FIFO byte valid |
| fifo_ready | output | 1 | Block takes the FIFO byte |
| fifo_data | input | 8 | Transmit FIFO byte |
| tx_valid | output | 1 | Byte offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts byte |
| tx_data | output | 8 | Byte to transmitter |

## Verification
The bench targets the interaction of the flow controls. It sends errored pause characters with the error check on and off. A design that ignored the error bit would stall the transmitter on line noise. It also sends pause characters with detection or asynchronous mode off, and a character that equals both registers, where a wrong priority would leave the transmitter running. On the transmit side, a special-character request arrives both before and after a FIFO byte has been offered. A design that preempted a byte already on offer would break the handshake, and one that queued the request behind the FIFO would lose the ordering. The bench also checks that consumed flow characters are taken while the consumer is stalled, since a design that waited would deadlock the receive path.

// File: rtl/spchar_pkg.sv
package spchar_pkg;
  localparam int CHAR_W = 8;
  localparam int N_CHR  = 2;
  typedef enum logic { SEL_RESUME = 1'b0, SEL_PAUSE = 1'b1 } chr_sel_e;
endpackage

// File: rtl/spchar_regs.sv
module spchar_regs #(
  parameter int W = spchar_pkg::CHAR_W,
  parameter int N = spchar_pkg::N_CHR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      we,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] chars
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     chars[i] <= '0;
      else if (we[i]) chars[i] <= wdata;
    end
    // R1: an unwritten register keeps its value
    p_hold_unwritten_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(chars[i]));
  end
endmodule

// File: rtl/spchar_rx.sv
module spchar_rx #(
  parameter int W = spchar_pkg::CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_async,
  input  logic         cfg_detect,
  input  logic         cfg_flow,
  input  logic         cfg_err_chk,
  input  logic [W-1:0] chr_a,
  input  logic [W-1:0] chr_b,
  input  logic         rx_valid,
  output logic         rx_ready,
  input  logic [W-1:0] rx_data,
  input  logic         rx_err,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_err,
  output logic         out_hit_a,
  output logic         out_hit_b,
  output logic         stop
);
  logic detect_on, flow_on, check_ok, hit_a, hit_b, consume, taken;

  assign detect_on = cfg_async & cfg_detect;
  assign flow_on   = detect_on & cfg_flow;
  assign check_ok  = detect_on & (~rx_err | cfg_err_chk);
  assign hit_a     = check_ok & (rx_data == chr_a);
  assign hit_b     = check_ok & (rx_data == chr_b);
  assign consume   = flow_on & (hit_a | hit_b);

  assign out_valid = rx_valid & ~consume;
  assign rx_ready  = consume | out_ready;
  assign out_data  = rx_data;
  assign out_err   = rx_err;
  assign out_hit_a = hit_a;
  assign out_hit_b = hit_b;
  assign taken     = rx_valid & consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stop <= 1'b0;
    else if (!flow_on)       stop <= 1'b0;
    else if (taken && hit_b) stop <= 1'b1;
    else if (taken && hit_a) stop <= 1'b0;
  end

  // R5: a consumed pause character raises stop
  p_pause_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_on && rx_valid && rx_data == chr_b && (!rx_err || cfg_err_chk)) |=> stop);
  // R5: without a resume character stop holds in flow mode
  p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && flow_on && !(rx_valid && rx_data == chr_a)) |=> stop);
  // R9: flow characters never stall on the consumer
  p_consume_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_on && rx_valid && rx_data == chr_a && (!rx_err || cfg_err_chk)) |-> (rx_ready && !out_valid));
  // R10: leaving flow mode releases stop
  p_noflow_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_async && cfg_detect && cfg_flow) |=> !stop);
endmodule

// File: rtl/spchar_tx.sv
module spchar_tx #(
  parameter int W = spchar_pkg::CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic [W-1:0] chr_a,
  input  logic [W-1:0] chr_b,
  input  logic         sc_req,
  input  logic         sc_sel,
  output logic         sc_ack,
  input  logic         fifo_valid,
  output logic         fifo_ready,
  input  logic [W-1:0] fifo_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [W-1:0] tx_data
);
  import spchar_pkg::*;
  logic     pend_q, fifo_busy_q, use_fifo;
  chr_sel_e sel_q;

  assign use_fifo   = fifo_busy_q | (~pend_q & ~stop);
  assign tx_valid   = use_fifo ? fifo_valid : pend_q;
  assign tx_data    = use_fifo ? fifo_data : ((sel_q == SEL_PAUSE) ? chr_b : chr_a);
  assign fifo_ready = use_fifo & tx_ready;
  assign sc_ack     = ~use_fifo & pend_q & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      sel_q       <= SEL_RESUME;
      fifo_busy_q <= 1'b0;
    end else begin
      fifo_busy_q <= use_fifo & fifo_valid & ~tx_ready;
      if (sc_ack) pend_q <= 1'b0;
      else if (sc_req && !pend_q) begin
        pend_q <= 1'b1;
        sel_q  <= chr_sel_e'(sc_sel);
      end
    end
  end

  // R8: an offer is held until taken
  p_offer_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R7: acknowledge is a single-cycle pulse
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ack |=> !sc_ack);
  // R6: no fresh FIFO byte while stopped
  p_stop_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !fifo_busy_q) |-> !fifo_ready);
endmodule

// File: rtl/spchar_flow.sv
module spchar_flow #(
  parameter int W = spchar_pkg::CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_async,
  input  logic         cfg_detect,
  input  logic         cfg_flow,
  input  logic         cfg_err_chk,
  input  logic [1:0]   chr_we,
  input  logic [W-1:0] chr_wdata,
  input  logic         rx_valid,
  output logic         rx_ready,
  input  logic [W-1:0] rx_data,
  input  logic         rx_err,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_err,
  output logic         out_hit_a,
  output logic         out_hit_b,
  output logic         tx_stop,
  input  logic         sc_req,
  input  logic         sc_sel,
  output logic         sc_ack,
  input  logic         fifo_valid,
  output logic         fifo_ready,
  input  logic [W-1:0] fifo_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [W-1:0] tx_data
);
  logic [1:0][W-1:0] chars;

  spchar_regs #(.W(W), .N(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(chr_we), .wdata(chr_wdata), .chars(chars));

  spchar_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cfg_async(cfg_async), .cfg_detect(cfg_detect), .cfg_flow(cfg_flow),
    .cfg_err_chk(cfg_err_chk), .chr_a(chars[0]), .chr_b(chars[1]),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_err(out_err), .out_hit_a(out_hit_a), .out_hit_b(out_hit_b),
    .stop(tx_stop));

  spchar_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .stop(tx_stop),
    .chr_a(chars[0]), .chr_b(chars[1]),
    .sc_req(sc_req), .sc_sel(sc_sel), .sc_ack(sc_ack),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data));
endmodule

// File: tb/spchar_flow_test.sv
module spchar_flow_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_async = 1'b1, cfg_detect = 1'b0, cfg_flow = 1'b0, cfg_err_chk = 1'b0;
  logic [1:0] chr_we = '0;
  logic [7:0] chr_wdata = '0, rx_data = '0, out_data, fifo_data = '0, tx_data;
  logic rx_valid = 1'b0, rx_ready, rx_err = 1'b0;
  logic out_valid, out_ready = 1'b1, out_err, out_hit_a, out_hit_b, tx_stop;
  logic sc_req = 1'b0, sc_sel = 1'b0, sc_ack;
  logic fifo_valid = 1'b0, fifo_ready, tx_valid, tx_ready = 1'b0;
  int checks = 0, bad = 0;
  logic [10:0] expq[$];

  always #10 clk = ~clk;

  spchar_flow uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: {data, err, hit_a, hit_b}
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0)
        chk(1'b0, "R2 unexpected output", {out_data, out_err, out_hit_a, out_hit_b}, 0);
      else begin
        logic [10:0] e;
        e = expq.pop_front();
        chk({out_data, out_err, out_hit_a, out_hit_b} == e, "R2/R3/R4 output item",
            {out_data, out_err, out_hit_a, out_hit_b}, e);
      end
    end
  end

  task automatic wr(input int idx, input logic [7:0] v);
    @(negedge clk); chr_we = 2'b01 << idx; chr_wdata = v;
    @(negedge clk); chr_we = '0;
  endtask

  task automatic send(input logic [7:0] d, input logic e, input bit pass, input bit ha, input bit hb);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    if (pass) expq.push_back({d, e, ha, hb});
    do @(posedge clk); while (!rx_ready);
    @(negedge clk); rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic special(input logic s);
    @(negedge clk); sc_req = 1'b1; sc_sel = s;
    @(negedge clk); sc_req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_stop == 1'b0, "R10 stop after reset", tx_stop, 0);
    // R1: reset value seen through a special send of register B
    special(1'b1);
    chk(tx_valid && tx_data == 8'h00, "R1 reset register B", tx_data, 0);
    tx_ready = 1'b1; #1;
    chk(sc_ack == 1'b1, "R7 ack pulse", sc_ack, 1);
    @(negedge clk);
    chk(sc_ack == 1'b0 && tx_valid == 1'b0, "R7 ack one cycle", sc_ack, 0);
    tx_ready = 1'b0;

    wr(0, 8'h11); wr(1, 8'h13);
    // R2 plain detect
    cfg_detect = 1'b1;
    send(8'h41, 0, 1, 0, 0);
    send(8'h11, 0, 1, 1, 0);
    send(8'h13, 0, 1, 0, 1);
    // R3 detection off / non-async
    cfg_detect = 1'b0; send(8'h11, 0, 1, 0, 0);
    cfg_detect = 1'b1; cfg_flow = 1'b1; cfg_async = 1'b0;
    send(8'h13, 0, 1, 0, 0);
    @(negedge clk);
    chk(tx_stop == 1'b0, "R3 no stop when not async", tx_stop, 0);
    cfg_async = 1'b1;
    // R4 errored pause skipped
    send(8'h13, 1, 1, 0, 0);
    @(negedge clk);
    chk(tx_stop == 1'b0, "R4 errored pause ignored", tx_stop, 0);
    // R9 consumed char taken while stalled, normal char waits
    out_ready = 1'b0;
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h42; #1;
    chk(rx_ready == 1'b0, "R9 passed char stalls", rx_ready, 0);
    rx_data = 8'h13; #1;
    chk(rx_ready == 1'b1 && out_valid == 1'b0, "R9 R5 pause consumed while stalled", rx_ready, 1);
    @(negedge clk); rx_valid = 1'b0; out_ready = 1'b1;
    chk(tx_stop == 1'b1, "R5 pause sets stop", tx_stop, 1);
    // R6 FIFO gated
    fifo_valid = 1'b1; fifo_data = 8'h55; tx_ready = 1'b1; #1;
    chk(tx_valid == 1'b0 && fifo_ready == 1'b0, "R6 fifo held while stopped", tx_valid, 0);
    // R7 special goes while stopped
    special(1'b0); #1;
    chk(tx_valid && tx_data == 8'h11 && sc_ack, "R7 special while stopped", tx_data, 8'h11);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R6 fifo still held", tx_valid, 0);
    // R5 resume clears; errored resume with err check on
    cfg_err_chk = 1'b1;
    send(8'h11, 1, 0, 0, 0);
    chk(tx_stop == 1'b0, "R4 R5 errored resume processed", tx_stop, 0);
    #1;
    chk(tx_valid && tx_data == 8'h55 && fifo_ready, "R6 fifo released", tx_data, 8'h55);
    fifo_valid = 1'b0; tx_ready = 1'b0;
    // R7 ordering: special ahead of waiting FIFO byte
    special(1'b1);
    fifo_valid = 1'b1; fifo_data = 8'h66; #1;
    chk(tx_data == 8'h13 && !fifo_ready, "R7 special before fifo", tx_data, 8'h13);
    tx_ready = 1'b1;
    @(negedge clk);
    chk(tx_data == 8'h66 && fifo_ready && !sc_ack, "R7 fifo after special", tx_data, 8'h66);
    tx_ready = 1'b0;
    // R8 offered byte not preempted
    special(1'b0); #1;
    chk(tx_valid && tx_data == 8'h66, "R8 offer held over request", tx_data, 8'h66);
    tx_ready = 1'b1; @(negedge clk); fifo_valid = 1'b0; #1;
    chk(tx_data == 8'h11 && sc_ack, "R8 R7 special after held byte", tx_data, 8'h11);
    @(negedge clk); tx_ready = 1'b0;
    // R5 both registers equal: pause wins
    wr(0, 8'h20); wr(1, 8'h20);
    send(8'h20, 0, 0, 0, 0);
    chk(tx_stop == 1'b1, "R5 double match pauses", tx_stop, 1);
    // R10 leave flow mode
    cfg_flow = 1'b0; @(negedge clk);
    chk(tx_stop == 1'b0, "R10 flow off clears stop", tx_stop, 0);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R2 all items seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule